// File: doc/BRIEF.md
# Burst Read Data Sequencer

This block is the synchronous burst read output path of a 16-bit memory. A host first writes a small configuration register. It then holds chip select low and pulses a start strobe together with a base address. After a fixed initial latency, the block reads words from an internal array in linear order and drives them on a 16-bit data bus with its output enable set. Alongside the data it drives a wait/ready flag, so the receiving side knows when the bus carries valid data.

Four configuration fields set the output timing at run time:
- the level at which the wait flag is active;
- whether each word is held for one clock or for two;
- whether the wait flag changes together with the data or one clock ahead of it;
- whether data is launched on the rising clock edge or half a clock later, on the falling edge.

A fifth field names the burst order. Only linear order exists. A request for any other order is still served linearly, and it sets a sticky error flag.

The block takes a copy of the configuration at each burst start. Writes made while a burst is running therefore take effect at the next start. The burst wraps inside an aligned group of eight words and runs until chip select is released.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the block drives `dq_oe` = 0, `dq` = 0, `wait_flag` = 1 and `cfg_err` = 0. The reset configuration is: wait active low, 1-clock hold, wait changes with the data, linear order, rising-edge launch.
- R2: The start edge is the clock edge at which `burst_start` = 1 is sampled with `cs_n` = 0. From that edge on, `dq_oe` = 1. The first valid word appears at the second edge after the start edge. Between the start edge and the first valid word, `dq` = 0. When `cfg_wdata[8]` = 0, the wait flag shows not-ready for those two clocks.
- R3: Let B be the base address, k the word index counted from 0, and & the bitwise AND. Words are read at address (B & ~7) | ((B + k) mod 8): linear order, wrapping inside the aligned group of eight words, repeating until `cs_n` rises. The word stored at address a is the low 16 bits of a*40503 + 4660.
- R4: When `cfg_wdata[9]` = 1, each word stays on `dq` for two clocks before the next word. When it is 0, a new word appears every clock.
- R5: When `cfg_wdata[8]` = 1, the wait flag shows ready one clock before the first valid word, so it shows not-ready only during the clock after the start edge.
- R6: When `cfg_wdata[10]` = 1, the wait flag is active high; when it is 0, the flag is active low. While no burst runs, the flag sits at its inactive level for the configured polarity.
- R7: When `cfg_wdata[6]` = 1, outputs change at the rising edge. When it is 0, the same values appear half a clock later, at the falling edge.
- R8: At the first rising edge with `cs_n` = 1, the burst ends: `dq_oe` = 0, `dq` = 0 and the wait flag goes to its inactive level.
- R9: Writing `cfg_wdata[7]` = 0 sets `cfg_err`, which stays set until reset. Bursts still run in linear order.
- R10: A configuration write made during a burst leaves that burst's data, wait flag and launch edge unchanged.
- R11: A start strobe while `cs_n` = 1 is ignored: `dq_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration bits 10 down to 6 |
| cs_n | input | 1 | Active-low chip select; a rising edge ends the burst |
| burst_start | input | 1 | Burst start strobe |
| start_addr | input | ADDR_W | Base word address of the burst |
| dq | output | 16 | Data bus |
| dq_oe | output | 1 | Data bus output enable |
| wait_flag | output | 1 | Wait/ready indicator at the configured polarity |
| cfg_err | output | 1 | Sticky flag: a non-linear order was requested |

## Verification
The assertions assume the following about the inputs:
- `cs_n` stays low for the whole burst, and a rise of `cs_n` is the only way a burst ends.
- Any restart happens through a fresh start strobe.
- The launch edge is not changed between two bursts that follow each other with no idle cycle between them.

The stimulus keeps within these limits. Every burst is preceded by a configuration write and an idle cycle. Each burst lasts between ten and thirty clocks before chip select rises. Configuration writes during a burst are the only changes made while a burst runs.

// File: rtl/bst_pkg.sv
`timescale 1ns/1ps
package bst_pkg;
  localparam int unsigned WORD_W = 16;

  // Configuration bit positions as seen on the write port
  localparam int unsigned CFG_POL_BIT   = 10;
  localparam int unsigned CFG_HOLD_BIT  = 9;
  localparam int unsigned CFG_EARLY_BIT = 8;
  localparam int unsigned CFG_ORDER_BIT = 7;
  localparam int unsigned CFG_EDGE_BIT  = 6;

  typedef struct packed {
    logic pol_high;
    logic hold_two;
    logic wait_early;
    logic rise_edge;
  } bst_cfg_t;

  localparam bst_cfg_t CFG_RESET = '{pol_high: 1'b0, hold_two: 1'b0,
                                     wait_early: 1'b0, rise_edge: 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} seq_state_e;

  // Stored word content as a function of its address
  function automatic logic [WORD_W-1:0] word_pattern(input int unsigned addr);
    logic [31:0] prod;
    prod = addr * 32'd40503 + 32'd4660;
    return prod[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/bst_cfg_reg.sv
`timescale 1ns/1ps
module bst_cfg_reg
  import bst_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic [CFG_POL_BIT:CFG_EDGE_BIT]     wdata_i,
  output bst_cfg_t                            cfg_o,
  output logic                                err_o
);
  bst_cfg_t cfg_q, cfg_d;
  logic     err_q, err_d;

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (load_i) begin
      cfg_d.pol_high   = wdata_i[CFG_POL_BIT];
      cfg_d.hold_two   = wdata_i[CFG_HOLD_BIT];
      cfg_d.wait_early = wdata_i[CFG_EARLY_BIT];
      cfg_d.rise_edge  = wdata_i[CFG_EDGE_BIT];
      // only linear order exists; anything else is flagged and served linearly
      if (!wdata_i[CFG_ORDER_BIT]) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  assert_err_on_bad_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wdata_i[CFG_ORDER_BIT]) |=> err_q);
endmodule

// File: rtl/bst_word_rom.sv
`timescale 1ns/1ps
module bst_word_rom
  import bst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = word_pattern(g);
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/bst_seq_core.sv
`timescale 1ns/1ps
module bst_seq_core
  import bst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned LATENCY   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  bst_cfg_t          cfg_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              oe_o,
  output logic [WORD_W-1:0] dq_o,
  output logic              wait_o,
  output logic              rise_o
);
  localparam int unsigned OFF_W = $clog2(BURST_LEN);
  localparam int unsigned HI_W  = ADDR_W - OFF_W;
  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(LATENCY - 1);

  seq_state_e        state_q, state_d;
  logic [HI_W-1:0]   base_hi_q, base_hi_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              ph_q, ph_d;
  logic [CNT_W-1:0]  lat_q, lat_d;
  bst_cfg_t          snap_q, snap_d;
  logic              oe_q, oe_d;
  logic              wact_q, wact_d;
  logic [WORD_W-1:0] dq_q, dq_d;
  logic              load_word;
  logic [CNT_W-1:0]  lat_inc;

  assign lat_inc = lat_q + 1'b1;

  always_comb begin
    state_d   = state_q;
    base_hi_d = base_hi_q;
    off_d     = off_q;
    ph_d      = ph_q;
    lat_d     = lat_q;
    snap_d    = snap_q;
    oe_d      = oe_q;
    wact_d    = wact_q;
    load_word = 1'b0;
    if (cs_ni) begin
      state_d = S_IDLE;
      oe_d    = 1'b0;
      wact_d  = 1'b0;
      snap_d  = cfg_i;
    end else if (start_i) begin
      state_d   = S_LAT;
      base_hi_d = base_i[ADDR_W-1:OFF_W];
      off_d     = base_i[OFF_W-1:0];
      ph_d      = 1'b0;
      lat_d     = '0;
      snap_d    = cfg_i;
      oe_d      = 1'b1;
      wact_d    = !(cfg_i.wait_early && (LATENCY == 1));
    end else begin
      unique case (state_q)
        S_IDLE: snap_d = cfg_i;
        S_LAT: begin
          if (lat_q == LAT_LAST) begin
            state_d   = S_DATA;
            wact_d    = 1'b0;
            load_word = 1'b1;
          end else begin
            lat_d  = lat_inc;
            wact_d = !(snap_q.wait_early && (lat_inc == LAT_LAST));
          end
        end
        S_DATA: begin
          load_word = 1'b1;
          if (snap_q.hold_two && !ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d  = 1'b0;
            off_d = off_q + 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign raddr_o = {base_hi_d, off_d};
  assign dq_d    = load_word ? rdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      base_hi_q <= '0;
      off_q     <= '0;
      ph_q      <= 1'b0;
      lat_q     <= '0;
      snap_q    <= CFG_RESET;
      oe_q      <= 1'b0;
      wact_q    <= 1'b0;
      dq_q      <= '0;
    end else begin
      state_q   <= state_d;
      base_hi_q <= base_hi_d;
      off_q     <= off_d;
      ph_q      <= ph_d;
      lat_q     <= lat_d;
      snap_q    <= snap_d;
      oe_q      <= oe_d;
      wact_q    <= wact_d;
      dq_q      <= dq_d;
    end
  end

  assign oe_o   = oe_q;
  assign dq_o   = dq_q;
  assign wait_o = snap_q.pol_high ? wact_q : ~wact_q;
  assign rise_o = snap_q.rise_edge;

  assert_idle_bus_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> (dq_q == '0 && !wact_q));

  assert_cs_ends_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!oe_q && state_q == S_IDLE));

  assert_not_ready_in_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LAT && !snap_q.wait_early) |-> (wact_q && dq_q == '0));

  assert_hold_pair_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && $past(state_q) == S_DATA && snap_q.hold_two && ph_q)
    |-> $stable(dq_q));

  assert_linear_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && $past(state_q) == S_DATA && !ph_q)
    |-> off_q == OFF_W'($past(off_q) + 1'b1));

  assert_snapshot_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && $past(state_q) != S_IDLE && !$past(start_i))
    |-> $stable(snap_q));
endmodule

// File: rtl/bst_edge_out.sv
`timescale 1ns/1ps
module bst_edge_out
  import bst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              oe_i,
  input  logic [WORD_W-1:0] dq_i,
  input  logic              wait_i,
  output logic              oe_o,
  output logic [WORD_W-1:0] dq_o,
  output logic              wait_o
);
  logic              oe_fq;
  logic [WORD_W-1:0] dq_fq;
  logic              wait_fq;

  // falling-edge copy of the rising-edge launch values
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_fq   <= 1'b0;
      dq_fq   <= '0;
      wait_fq <= !CFG_RESET.pol_high;
    end else begin
      oe_fq   <= oe_i;
      dq_fq   <= dq_i;
      wait_fq <= wait_i;
    end
  end

  assign oe_o   = rise_i ? oe_i   : oe_fq;
  assign dq_o   = rise_i ? dq_i   : dq_fq;
  assign wait_o = rise_i ? wait_i : wait_fq;

  assert_fall_copy_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dq_fq == $past(dq_i) && oe_fq == $past(oe_i)));
endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq
  import bst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned LATENCY   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_load,
  input  logic [CFG_POL_BIT:CFG_EDGE_BIT] cfg_wdata,
  input  logic                            cs_n,
  input  logic                            burst_start,
  input  logic [ADDR_W-1:0]               start_addr,
  output logic [WORD_W-1:0]               dq,
  output logic                            dq_oe,
  output logic                            wait_flag,
  output logic                            cfg_err
);
  logic [1:0]        rst_pipe_q, rst_pipe_d;
  logic              rst_int_n;
  bst_cfg_t          cfg;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;
  logic              core_oe, core_wait, core_rise;
  logic [WORD_W-1:0] core_dq;

  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_int_n = rst_pipe_q[1];

  bst_cfg_reg i_cfg_reg (
    .clk_i   (clk),
    .rst_ni  (rst_int_n),
    .load_i  (cfg_load),
    .wdata_i (cfg_wdata),
    .cfg_o   (cfg),
    .err_o   (cfg_err)
  );

  bst_word_rom #(.ADDR_W(ADDR_W)) i_word_rom (
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  bst_seq_core #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN),
    .LATENCY   (LATENCY)
  ) i_seq_core (
    .clk_i   (clk),
    .rst_ni  (rst_int_n),
    .cs_ni   (cs_n),
    .start_i (burst_start),
    .base_i  (start_addr),
    .cfg_i   (cfg),
    .raddr_o (raddr),
    .rdata_i (rdata),
    .oe_o    (core_oe),
    .dq_o    (core_dq),
    .wait_o  (core_wait),
    .rise_o  (core_rise)
  );

  bst_edge_out i_edge_out (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .rise_i (core_rise),
    .oe_i   (core_oe),
    .dq_i   (core_dq),
    .wait_i (core_wait),
    .oe_o   (dq_oe),
    .dq_o   (dq),
    .wait_o (wait_flag)
  );

  assert_no_start_without_cs_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n && !core_oe) |=> !core_oe);
endmodule

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;
  localparam int unsigned AW  = 6;
  localparam int unsigned BL  = 8;
  localparam int unsigned LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [10:6]   cfg_wdata = '0;
  logic          cs_n = 1'b1;
  logic          burst_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [15:0]   dq;
  logic          dq_oe, wait_flag, cfg_err;

  int tests = 0;
  int fails = 0;
  bit exp_err = 1'b0;

  logic [15:0] mid_dq, late_dq, prev_dq;
  logic        mid_oe, late_oe, prev_oe;
  logic        mid_w, late_w, prev_w;

  always #2.5 clk = ~clk;

  burst_read_seq #(.ADDR_W(AW), .BURST_LEN(BL), .LATENCY(LAT)) i_burst_read_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_wdata   (cfg_wdata),
    .cs_n        (cs_n),
    .burst_start (burst_start),
    .start_addr  (start_addr),
    .dq          (dq),
    .dq_oe       (dq_oe),
    .wait_flag   (wait_flag),
    .cfg_err     (cfg_err)
  );

  // One clock: sample between rising and falling edge, then just before the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
    mid_dq = dq; mid_oe = dq_oe; mid_w = wait_flag;
    #3.5;
    prev_dq = late_dq; prev_oe = late_oe; prev_w = late_w;
    late_dq = dq; late_oe = dq_oe; late_w = wait_flag;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int unsigned base, input int unsigned j,
                                           input bit hold2);
    int unsigned i, k, a;
    logic [31:0] p;
    if (j < LAT) return 16'h0000;
    i = j - LAT;
    k = hold2 ? i / 2 : i;
    a = (base & ~(BL - 1)) | ((base + k) % BL);
    p = a * 32'd40503 + 32'd4660;
    return p[15:0];
  endfunction

  function automatic bit exp_wact(input int unsigned j, input bit early);
    return (j < LAT) && !(early && (j == LAT - 1));
  endfunction

  // cfg vector: [4]=wait polarity, [3]=two-clock hold, [2]=early wait, [1]=linear, [0]=rising edge
  task automatic run_burst(input logic [4:0] cfg, input logic [AW-1:0] base,
                           input int n, input bit chg);
    logic [4:0] alt;
    string tdq, tw;
    bit ew;
    alt = ~cfg | 5'b00010;
    cfg_load = 1'b1; cfg_wdata = cfg;
    if (!cfg[1]) exp_err = 1'b1;
    tick();
    cfg_load = 1'b0;
    tick();
    cs_n = 1'b0; burst_start = 1'b1; start_addr = base;
    for (int j = 0; j < n; j++) begin
      tick();
      burst_start = 1'b0;
      if (chg && j == 3) begin
        cfg_load = 1'b1; cfg_wdata = alt;
      end else begin
        cfg_load = 1'b0;
      end
      tdq = chg ? "R10" : (cfg[3] ? "R4" : "R3");
      tw  = chg ? "R10" : (cfg[2] ? "R5" : ((j < LAT) ? "R2" : "R6"));
      ew  = cfg[4] ? exp_wact(j, cfg[2]) : !exp_wact(j, cfg[2]);
      check("R2 output enable", {15'd0, late_oe}, 16'h0001);
      check({tdq, " data"}, late_dq, exp_word(base, j, cfg[3]));
      check({tw, " wait"}, {15'd0, late_w}, {15'd0, ew});
      if (cfg[0]) begin
        check("R7 rising data", mid_dq, late_dq);
        check("R7 rising wait", {15'd0, mid_w}, {15'd0, late_w});
      end else begin
        check("R7 falling data", mid_dq, prev_dq);
        check("R7 falling oe", {15'd0, mid_oe}, {15'd0, prev_oe});
        check("R7 falling wait", {15'd0, mid_w}, {15'd0, prev_w});
      end
    end
    cs_n = 1'b1; cfg_load = 1'b0;
    tick();
    check("R8 oe off", {15'd0, late_oe}, 16'h0000);
    check("R8 bus zero", late_dq, 16'h0000);
    check("R8 wait idle", {15'd0, late_w}, {15'd0, !(chg ? alt[4] : cfg[4])});
    check("R9 sticky error", {15'd0, cfg_err}, {15'd0, exp_err});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    late_dq = '0; late_oe = 1'b0; late_w = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 reset oe", {15'd0, late_oe}, 16'h0000);
    check("R1 reset data", late_dq, 16'h0000);
    check("R1 reset wait", {15'd0, late_w}, 16'h0001);
    check("R1 reset err", {15'd0, cfg_err}, 16'h0000);

    // R11: a start strobe with chip select high is ignored
    burst_start = 1'b1;
    repeat (3) begin
      tick();
      check("R11 ignored start oe", {15'd0, late_oe}, 16'h0000);
      check("R11 ignored start wait", {15'd0, late_w}, 16'h0001);
    end
    burst_start = 1'b0;

    // directed corner cases
    run_burst(5'b00011, 6'd5, 14, 1'b0);    // wrap from mid-group, 1-clock hold
    run_burst(5'b11111, 6'd62, 22, 1'b0);   // active high, hold 2, early wait
    run_burst(5'b00110, 6'd16, 12, 1'b0);   // early wait, falling edge
    check("R9 no error yet", {15'd0, cfg_err}, 16'h0000);
    run_burst(5'b10100, 6'd9, 14, 1'b0);    // order bit 0: still linear, error raised
    check("R9 error raised", {15'd0, cfg_err}, 16'h0001);
    run_burst(5'b01011, 6'd33, 16, 1'b1);   // config rewrite during the burst

    // idle polarity follows the register between bursts
    cfg_load = 1'b1; cfg_wdata = 5'b10011;
    tick(); cfg_load = 1'b0; tick(); tick();
    check("R6 idle level high polarity", {15'd0, late_w}, 16'h0000);
    cfg_load = 1'b1; cfg_wdata = 5'b00011;
    tick(); cfg_load = 1'b0; tick(); tick();
    check("R6 idle level low polarity", {15'd0, late_w}, 16'h0001);

    for (int b = 0; b < 40; b++) begin
      logic [4:0] c;
      c = 5'($urandom % 32);
      run_burst(c, AW'($urandom % 64), 10 + int'($urandom % 20), ($urandom % 4) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule